// File: doc/BRIEF.md
# Ordering Table Clear DMA

This block is a single-channel DMA engine that builds a backward-linked list of pointer words in memory. Software programs a start address and an entry count, then writes a control word. When the control word is exactly the start code, the engine walks downward from the start address. It issues one 32-bit write per entry through a valid/ready memory port. Every entry except the lowest holds a 24-bit pointer to the word just below it. The lowest entry holds an end-of-list marker. The engine moves no data from a source and reads nothing from memory; every word it writes is generated internally.

Completion follows the same path for the normal walk and for a rejected mode. The busy bit (bit 24 of the control word) clears, and the interrupt request pulses for one cycle.

The controller has four states:
- `ST_IDLE`: waits for a control write.
- `ST_LOAD`: copies the address and count into the walker.
- `ST_WRITE`: holds a write request until it is accepted.
- `ST_DONE`: pulses the interrupt and clears the busy bit.

The transitions are:
- IDLE→LOAD on a start-code write.
- IDLE→DONE on a rejected-mode write.
- LOAD→WRITE unconditionally.
- WRITE→WRITE on a stall or on a non-final accept.
- WRITE→DONE on the final accept.
- DONE→IDLE unconditionally.

Top module: `otc_dma`

## Requirements
- R1: Register offset 2 is the control word. A write of exactly 0x11000002 to it while idle starts a walk. From the following cycle until completion, bit 24 of the control word reads back 1.
- R2: A walk with count N performs max(N,1) memory writes, in order, at addresses base, base−4, base−8, … (modulo 2^32).
- R3: Every write except the last carries (address − 4) masked to its low 24 bits, with bits 31:24 zero.
- R4: The last write of a walk carries 0x00FFFFFF.
- R5: A count of zero produces exactly one write, the terminator 0x00FFFFFF at the start address.
- R6: While mem_valid is high and mem_ready is low, mem_valid, mem_addr and mem_data hold their values. The walk advances only on an accepted write.
- R7: irq is high for exactly one cycle, in the cycle right after the final write is accepted. Bit 24 reads 1 in that cycle and 0 afterwards. All other control bits keep their written values.
- R8: A control write while idle, with bit 24 set and a value other than 0x11000002, produces no memory write. irq pulses in the next cycle, then bit 24 clears and the other bits are kept.
- R9: A control write with bit 24 clear is stored as written and produces no memory write and no irq.
- R10: Writes to any register while bit 24 of the control word is set are ignored.
- R11: After reset all registers read 0, and mem_valid and irq are 0.
- R12: Offset 0 holds the start address and offset 1 holds the count (low 16 bits). Offset 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 32 | Memory write data |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps the count from 0 to 6 across three start addresses and three acceptance patterns:
- **Acceptance patterns.** Always ready, ready on alternate cycles, and ready every third cycle. These separate an engine that steps on acceptance from one that steps on its own request.
- **Start addresses.** A start address near zero shows the wrap below zero. A start address with nonzero upper bits shows the 24-bit link mask.
- **Count sweep.** Count zero separates the single-terminator case from the general walk.

Further runs cover three more cases:
- Register pokes during a long walk, which must have no effect.
- A rejected control value with the busy bit set.
- A control value with the busy bit clear.

// File: rtl/otc_pkg.sv
package otc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WRITE,
        ST_DONE
    } otc_state_e;

    localparam logic [31:0] OTC_GO_WORD  = 32'h1100_0002;
    localparam int          OTC_BUSY_BIT = 24;

    localparam logic [1:0]  OFS_BASE  = 2'd0;
    localparam logic [1:0]  OFS_COUNT = 2'd1;
    localparam logic [1:0]  OFS_CTRL  = 2'd2;

endpackage

// File: rtl/otc_regs.sv
module otc_regs
    import otc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              clear_busy,
    output logic [31:0]       reg_rdata,
    output logic [ADDR_W-1:0] base_q,
    output logic [CNT_W-1:0]  count_q,
    output logic              busy,
    output logic              kick_ok,
    output logic              kick_bad
);

    logic [31:0] ctrl_q;
    logic        wr_open;
    logic        ctrl_wr;

    assign busy     = ctrl_q[OTC_BUSY_BIT];
    assign wr_open  = reg_we && !busy;
    assign ctrl_wr  = wr_open && (reg_addr == OFS_CTRL);
    assign kick_ok  = ctrl_wr && (reg_wdata == OTC_GO_WORD);
    assign kick_bad = ctrl_wr && (reg_wdata != OTC_GO_WORD) && reg_wdata[OTC_BUSY_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            count_q <= '0;
            ctrl_q  <= '0;
        end else begin
            if (wr_open && reg_addr == OFS_BASE) begin
                base_q <= reg_wdata[ADDR_W-1:0];
            end
            if (wr_open && reg_addr == OFS_COUNT) begin
                count_q <= reg_wdata[CNT_W-1:0];
            end
            if (ctrl_wr) begin
                ctrl_q <= reg_wdata;
            end else if (clear_busy) begin
                ctrl_q[OTC_BUSY_BIT] <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_BASE:  reg_rdata[ADDR_W-1:0] = base_q;
            OFS_COUNT: reg_rdata[CNT_W-1:0]  = count_q;
            OFS_CTRL:  reg_rdata             = ctrl_q;
            default:   reg_rdata             = '0;
        endcase
    end

    // R10: register contents frozen while a walk is in flight
    a_r10_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we) |=> ($stable(base_q) && $stable(count_q)));

endmodule

// File: rtl/otc_walker.sv
module otc_walker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int LINK_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [CNT_W-1:0]  count_q,
    output logic              last,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_data
);

    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(4);
    localparam logic [LINK_W-1:0] LSTEP  = LINK_W'(4);
    localparam logic [31:0]       TERM   = 32'((64'd1 << LINK_W) - 64'd1);

    logic [ADDR_W-1:0] cur_q;
    logic [CNT_W-1:0]  left_q;
    logic [LINK_W-1:0] link_low;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            left_q <= '0;
        end else if (load) begin
            cur_q  <= base_q;
            left_q <= (count_q == '0) ? CNT_W'(1) : count_q;
        end else if (step) begin
            cur_q  <= cur_q - STRIDE;
            left_q <= left_q - CNT_W'(1);
        end
    end

    assign last     = (left_q == CNT_W'(1));
    assign link_low = cur_q[LINK_W-1:0] - LSTEP;
    assign mem_addr = cur_q;

    always_comb begin
        mem_data = '0;
        if (last) begin
            mem_data = TERM;
        end else begin
            mem_data[LINK_W-1:0] = link_low;
        end
    end

endmodule

// File: rtl/otc_fsm.sv
module otc_fsm
    import otc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kick_ok,
    input  logic kick_bad,
    input  logic mem_ready,
    input  logic last,
    output logic load,
    output logic step,
    output logic mem_valid,
    output logic irq,
    output logic clear_busy
);

    otc_state_e state_q, state_d;
    logic       accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign accept = (state_q == ST_WRITE) && mem_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (kick_ok) begin
                    state_d = ST_LOAD;
                end else if (kick_bad) begin
                    state_d = ST_DONE;
                end
            end
            ST_LOAD:  state_d = ST_WRITE;
            ST_WRITE: begin
                if (accept && last) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load       = 1'b0;
        step       = 1'b0;
        mem_valid  = 1'b0;
        irq        = 1'b0;
        clear_busy = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_LOAD:  load = 1'b1;
            ST_WRITE: begin
                mem_valid = 1'b1;
                step      = accept && !last;
            end
            ST_DONE: begin
                irq        = 1'b1;
                clear_busy = 1'b1;
            end
            default: ;
        endcase
    end

    // R7: completion pulse follows the final accepted write
    a_r7_irq_after_final: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && last) |=> irq);

    // R7: the pulse lasts one cycle
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R1: a start code leads to a write request two cycles later
    a_r1_start_path: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && kick_ok) |=> !mem_valid ##1 mem_valid);

endmodule

// File: rtl/otc_dma.sv
module otc_dma #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int LINK_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_data,
    output logic              irq
);

    localparam logic [31:0] TERM_W = 32'((64'd1 << LINK_W) - 64'd1);

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  count_q;
    logic              busy;
    logic              kick_ok;
    logic              kick_bad;
    logic              clear_busy;
    logic              load;
    logic              step;
    logic              last;

    otc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .clear_busy (clear_busy),
        .reg_rdata  (reg_rdata),
        .base_q     (base_q),
        .count_q    (count_q),
        .busy       (busy),
        .kick_ok    (kick_ok),
        .kick_bad   (kick_bad)
    );

    otc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick_ok    (kick_ok),
        .kick_bad   (kick_bad),
        .mem_ready  (mem_ready),
        .last       (last),
        .load       (load),
        .step       (step),
        .mem_valid  (mem_valid),
        .irq        (irq),
        .clear_busy (clear_busy)
    );

    otc_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINK_W(LINK_W)) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .base_q   (base_q),
        .count_q  (count_q),
        .last     (last),
        .mem_addr (mem_addr),
        .mem_data (mem_data)
    );

    // R6: a stalled request is held unchanged
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R2: an accepted link word is followed by the word 4 bytes lower
    a_r2_descend: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_data != TERM_W) |=>
            (mem_valid && mem_addr == $past(mem_addr) - ADDR_W'(4)));

    // R8: no request is raised while completion is signalled
    a_r8_quiet_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !mem_valid);

    // R1: busy is set whenever a write request is raised
    a_r1_busy_during_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> busy);

endmodule

// File: tb/tb_otc_dma.sv
module tb_otc_dma;

    localparam logic [31:0] GO   = 32'h1100_0002;
    localparam logic [31:0] TERM = 32'h00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int mode = 0;

    logic [31:0] rec_addr [0:63];
    logic [31:0] rec_data [0:63];
    int rec_n, irq_cnt, irq_at, last_acc, samp, busy_at_irq;
    logic        prev_stall;
    logic [31:0] prev_addr, prev_data;

    otc_dma dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic clear_rec();
        rec_n = 0; irq_cnt = 0; irq_at = -1; last_acc = -1; samp = 0;
        busy_at_irq = 0; prev_stall = 1'b0;
    endtask

    task automatic tick();
        bit rdy;
        @(negedge clk);
        unique case (mode)
            1:       rdy = (cyc % 2) == 0;
            2:       rdy = (cyc % 3) == 0;
            default: rdy = 1'b1;
        endcase
        mem_ready = rdy;
        #1;
        if (prev_stall) begin
            chk(mem_valid && mem_addr == prev_addr && mem_data == prev_data,
                "R6 stalled request held", mem_addr, prev_addr);
        end
        prev_stall = mem_valid && !mem_ready;
        prev_addr  = mem_addr;
        prev_data  = mem_data;
        if (mem_valid && mem_ready) begin
            if (rec_n < 64) begin
                rec_addr[rec_n] = mem_addr;
                rec_data[rec_n] = mem_data;
            end
            rec_n = rec_n + 1;
            last_acc = samp;
        end
        if (irq) begin
            irq_cnt = irq_cnt + 1;
            irq_at = samp;
            busy_at_irq = (reg_addr == 2'd2) ? int'(reg_rdata[24]) : -1;
        end
        samp = samp + 1;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run_case(input logic [31:0] base, input int count, input int m, input bit poke);
        int n;
        int extra;
        logic [31:0] rd;
        mode = m;
        n = (count == 0) ? 1 : count;
        reg_write(2'd0, base);
        reg_write(2'd1, 32'(count));
        reg_write(2'd2, GO);
        #1;
        chk(reg_rdata[24] == 1'b1, "R1 busy after start", {31'b0, reg_rdata[24]}, 32'd1);
        clear_rec();
        extra = -1;
        for (int i = 0; i < 600; i++) begin
            tick();
            if (poke && i == 1) begin
                reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'hDEAD_BEE0;
            end
            if (poke && i == 2) begin
                reg_addr = 2'd1; reg_wdata = 32'd3;
            end
            if (poke && i == 3) begin
                reg_addr = 2'd2; reg_wdata = GO;
            end
            if (poke && i == 4) begin
                reg_we = 1'b0;
            end
            if (extra < 0 && irq_cnt > 0) extra = 3;
            if (extra > 0) extra = extra - 1;
            if (extra == 0) break;
        end
        chk(rec_n == n, "R2 write count", 32'(rec_n), 32'(n));
        for (int k = 0; k < n && k < rec_n && k < 64; k++) begin
            logic [31:0] ea;
            logic [31:0] ed;
            ea = base - 32'(4 * k);
            ed = (k == n - 1) ? TERM : ((ea - 32'd4) & 32'h00FF_FFFF);
            chk(rec_addr[k] == ea, "R2 write address", rec_addr[k], ea);
            if (k == n - 1) begin
                if (count == 0) chk(rec_data[k] == ed, "R5 zero count terminator", rec_data[k], ed);
                else            chk(rec_data[k] == ed, "R4 terminator word", rec_data[k], ed);
            end else begin
                chk(rec_data[k] == ed, "R3 link word", rec_data[k], ed);
            end
        end
        chk(irq_cnt == 1, "R7 single irq pulse", 32'(irq_cnt), 32'd1);
        chk(irq_at == last_acc + 1, "R7 irq after final accept", 32'(irq_at), 32'(last_acc + 1));
        chk(busy_at_irq == 1, "R7 busy during irq cycle", 32'(busy_at_irq), 32'd1);
        reg_read(2'd2, rd);
        chk(rd == 32'h1000_0002, "R7 control after completion", rd, 32'h1000_0002);
        reg_read(2'd0, rd);
        chk(rd == base, poke ? "R10 base unchanged by busy write" : "R12 base readback", rd, base);
        reg_read(2'd1, rd);
        chk(rd == 32'(count), poke ? "R10 count unchanged by busy write" : "R12 count readback", rd, 32'(count));
    endtask

    initial begin
        logic [31:0] rd;
        logic [31:0] bases [0:2];
        bases[0] = 32'h0000_1000;
        bases[1] = 32'h0000_0010;
        bases[2] = 32'h1234_5678;
        clear_rec();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(mem_valid == 1'b0 && irq == 1'b0, "R11 outputs idle", {30'b0, mem_valid, irq}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), rd);
            chk(rd == 32'd0, "R11 register reset value", rd, 32'd0);
        end

        for (int b = 0; b < 3; b++)
            for (int c = 0; c <= 6; c++)
                for (int m = 0; m < 3; m++)
                    run_case(bases[b], c, m, 1'b0);

        run_case(32'h0000_0008, 5, 1, 1'b0);
        run_case(32'hFF00_0004, 3, 2, 1'b0);
        run_case(32'h0000_4000, 20, 1, 1'b1);

        reg_write(2'd3, 32'hFFFF_FFFF);
        reg_read(2'd3, rd);
        chk(rd == 32'd0, "R12 offset 3 reads zero", rd, 32'd0);

        mode = 0;
        clear_rec();
        reg_write(2'd2, 32'h1100_0003);
        #1;
        chk(irq == 1'b1, "R8 irq in cycle after rejected start", {31'b0, irq}, 32'd1);
        for (int i = 0; i < 10; i++) tick();
        chk(rec_n == 0, "R8 rejected mode writes nothing", 32'(rec_n), 32'd0);
        chk(irq_cnt == 0, "R8 irq not repeated", 32'(irq_cnt), 32'd0);
        reg_read(2'd2, rd);
        chk(rd == 32'h1000_0003, "R8 busy cleared, bits kept", rd, 32'h1000_0003);

        clear_rec();
        reg_write(2'd2, 32'h0000_0002);
        for (int i = 0; i < 10; i++) tick();
        chk(rec_n == 0, "R9 idle control writes nothing", 32'(rec_n), 32'd0);
        chk(irq_cnt == 0, "R9 idle control raises no irq", 32'(irq_cnt), 32'd0);
        reg_read(2'd2, rd);
        chk(rd == 32'h0000_0002, "R9 control stored as written", rd, 32'h0000_0002);

        run_case(32'h0000_0100, 2, 0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule